// File: doc/BRIEF.md
# PCI Target Transaction Decoder

This block listens to a 32-bit multiplexed PCI address/data bus from the target side. On the first clock in which the cycle-frame input is low after an idle bus, it captures the address and the bus command. It sorts the command into a class and decides whether to claim the transaction. Memory commands are claimed when the address falls in a memory window, and I/O commands when it falls in a separate I/O window. Each window is set by a base input and a mask input.

While the transaction runs, the block follows the data phases. For each phase it reports the byte-lane enables as active-high bits and counts the phases. It marks the final phase when the frame input returns high. For a claimed transaction it drives the active-low device-select output, together with an output enable, for the whole transaction. It then drives device-select high for one turnaround clock and releases it. Interrupt-acknowledge and special cycles are never claimed; the block only pulses an event flag for them. A special cycle whose address phase does not carry all-zero AD is flagged as malformed.

Top module: `pciTargetDecoder`

## Requirements
- R1: While reset is asserted, and after its release until the first claim, `devselOe` is 0 and `devselN` is 1. `cmdClass`, `phaseCount`, `lastPhase`, `eventPulse` and `badSpecial` are 0. Asserting reset in the middle of a claimed transaction releases `devselOe` at once.
- R2: The address phase is the first rising edge at which `frameN` is 0 while the bus is idle. From the next clock, `addrOut` holds the AD value sampled there, unchanged until the next address phase.
- R3: `cmdClass` shows the command sampled in the address phase, with this code-to-class map: 0000→1 (interrupt ack), 0001→2 (special), 0010→3 (I/O read), 0011→4 (I/O write), 0110→5 (mem read), 0111→6 (mem write), 1010→7 (config read), 1011→8 (config write), 1100→9 (mem read multiple), 1110→10 (mem read line), 1111→11 (mem write and invalidate).
- R4: The codes 0100, 0101, 1000, 1001 and 1101 give `cmdClass`=0 and are never claimed, whatever the address.
- R5: An address hits a window when (AD & mask) == (base & mask). Memory classes (5, 6, 9, 10, 11) use `memBase`/`memMask`, and I/O classes (3, 4) use `ioBase`/`ioMask`. Configuration, interrupt-acknowledge and special commands are never claimed.
- R6: For a claimed transaction, `devselN`=0 and `devselOe`=1 from the clock after the address phase through the clock of the final data phase.
- R7: In the clock after the final data phase of a claimed transaction, `devselN`=1 and `devselOe`=1. In the clock after that, `devselOe`=0.
- R8: Every clock after the address phase is a data phase. When `frameN` is sampled 1 in a data phase, that phase is the final one, and `lastPhase` is 1 for exactly the following clock.
- R9: One clock after each data phase, `laneEn` equals the bitwise inverse of the C/BE# value sampled in that phase (bit n enables byte lane n).
- R10: `phaseCount` becomes 0 after the address phase and counts the completed data phases of the transaction. It saturates at its all-ones value.
- R11: For an interrupt-acknowledge or special command, `eventPulse` is 1 for exactly the one clock after the address phase.
- R12: For a special command, `badSpecial` is 1 in the clock after the address phase if the sampled AD was not all zeros, and 0 otherwise.
- R13: An unclaimed transaction leaves `devselOe` at 0 for its whole length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low asynchronous reset |
| frameN | input | 1 | Active-low cycle frame |
| ad | input | 32 | Multiplexed address/data |
| cbeN | input | 4 | Command (address phase) / active-low byte enables (data phases) |
| memBase | input | 32 | Memory window base |
| memMask | input | 32 | Memory window compare mask |
| ioBase | input | 32 | I/O window base |
| ioMask | input | 32 | I/O window compare mask |
| cmdClass | output | 4 | Decoded command class (R3 encoding) |
| addrOut | output | 32 | Latched transaction address |
| laneEn | output | 4 | Active-high byte-lane enables of the last data phase |
| phaseCount | output | 8 | Data phases completed in the transaction |
| devselN | output | 1 | Active-low device-select claim |
| devselOe | output | 1 | Output enable for devselN |
| lastPhase | output | 1 | Final data phase has completed |
| eventPulse | output | 1 | Interrupt-ack or special cycle seen |
| badSpecial | output | 1 | Special cycle with non-zero address phase |

## Verification
The final-phase marking and the claim release share a clock edge. The same edge that sees `frameN` return high sets `lastPhase`, drives `devselN` high and holds `devselOe`. A transaction with a single data phase also puts the first lane-enable update and the phase-count step on that edge. The bench provokes this with one-phase claimed transactions and checks, in the one clock that follows, `lastPhase`, `devselN`=1 with `devselOe`=1, the lane enables and a count of one together. It then checks that the enable drops one clock later.

// File: rtl/pciTgtPkg.sv
package pciTgtPkg;

  typedef enum logic [3:0] {
    CLS_RSVD = 4'd0,
    CLS_IACK = 4'd1,
    CLS_SPEC = 4'd2,
    CLS_IORD = 4'd3,
    CLS_IOWR = 4'd4,
    CLS_MRD  = 4'd5,
    CLS_MWR  = 4'd6,
    CLS_CRD  = 4'd7,
    CLS_CWR  = 4'd8,
    CLS_MRDM = 4'd9,
    CLS_MRDL = 4'd10,
    CLS_MWRI = 4'd11
  } cmdClass_e;

  // strobes handed from control to datapath, one per bus event
  typedef struct packed {
    logic addrPhase;
    logic dataPhase;
    logic finalPhase;
    logic turnEnd;
  } strobe_t;

  function automatic cmdClass_e decodeCmd(input logic [3:0] code);
    cmdClass_e c;
    case (code)
      4'b0000: c = CLS_IACK;
      4'b0001: c = CLS_SPEC;
      4'b0010: c = CLS_IORD;
      4'b0011: c = CLS_IOWR;
      4'b0110: c = CLS_MRD;
      4'b0111: c = CLS_MWR;
      4'b1010: c = CLS_CRD;
      4'b1011: c = CLS_CWR;
      4'b1100: c = CLS_MRDM;
      4'b1110: c = CLS_MRDL;
      4'b1111: c = CLS_MWRI;
      default: c = CLS_RSVD;
    endcase
    return c;
  endfunction

  function automatic logic isMemClass(input cmdClass_e c);
    return (c == CLS_MRD) || (c == CLS_MWR) || (c == CLS_MRDM) ||
           (c == CLS_MRDL) || (c == CLS_MWRI);
  endfunction

  function automatic logic isIoClass(input cmdClass_e c);
    return (c == CLS_IORD) || (c == CLS_IOWR);
  endfunction

endpackage

// File: rtl/pciTgtDatapath.sv
module pciTgtDatapath
  import pciTgtPkg::*;
#(
  parameter int DW  = 32,
  parameter int PCW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DW-1:0]     ad,
  input  logic [DW/8-1:0]   cbeN,
  input  logic [DW-1:0]     memBase,
  input  logic [DW-1:0]     memMask,
  input  logic [DW-1:0]     ioBase,
  input  logic [DW-1:0]     ioMask,
  output logic              claimOk,
  output logic [DW-1:0]     addrQ,
  output cmdClass_e         classQ,
  output logic [DW/8-1:0]   laneEn,
  output logic [PCW-1:0]    phaseCount,
  output logic              eventPulse,
  output logic              badSpecial
);

  localparam int BEW = DW / 8;
  localparam logic [PCW-1:0] COUNT_MAX = {PCW{1'b1}};

  cmdClass_e       classNow;
  logic            memHit;
  logic            ioHit;
  logic [BEW-1:0]  laneNext;

  assign classNow = decodeCmd(cbeN[3:0]);
  assign memHit   = ((ad & memMask) == (memBase & memMask));
  assign ioHit    = ((ad & ioMask) == (ioBase & ioMask));

  always_comb begin
    claimOk = 1'b0;
    if (isMemClass(classNow))     claimOk = memHit;
    else if (isIoClass(classNow)) claimOk = ioHit;
  end

  for (genvar g = 0; g < BEW; g++) begin : gLane
    assign laneNext[g] = ~cbeN[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ      <= '0;
      classQ     <= CLS_RSVD;
      laneEn     <= '0;
      phaseCount <= '0;
      eventPulse <= 1'b0;
      badSpecial <= 1'b0;
    end else begin
      eventPulse <= 1'b0;
      badSpecial <= 1'b0;
      if (strb.addrPhase) begin
        addrQ      <= ad;
        classQ     <= classNow;
        laneEn     <= '0;
        phaseCount <= '0;
        eventPulse <= (classNow == CLS_IACK) || (classNow == CLS_SPEC);
        badSpecial <= (classNow == CLS_SPEC) && (ad != '0);
      end else if (strb.dataPhase) begin
        laneEn <= laneNext;
        if (phaseCount != COUNT_MAX) phaseCount <= phaseCount + 1'b1;
      end
    end
  end

  p_addr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.addrPhase |=> $stable(addrQ));

  p_count_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.addrPhase |=> (phaseCount == '0));

  p_event_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    eventPulse |=> !eventPulse);

endmodule

// File: rtl/pciTgtControl.sv
module pciTgtControl
  import pciTgtPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    frameN,
  input  logic    claimOk,
  output strobe_t strb,
  output logic    devselN,
  output logic    devselOe,
  output logic    lastPhase
);

  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_TURN} busState_e;
  busState_e busState;

  always_comb begin
    strb.addrPhase  = (busState == ST_IDLE) && !frameN;
    strb.dataPhase  = (busState == ST_DATA);
    strb.finalPhase = (busState == ST_DATA) && frameN;
    strb.turnEnd    = (busState == ST_TURN);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busState  <= ST_IDLE;
      devselN   <= 1'b1;
      devselOe  <= 1'b0;
      lastPhase <= 1'b0;
    end else begin
      case (busState)
        ST_IDLE: if (strb.addrPhase) begin
          busState <= ST_DATA;
          devselN  <= !claimOk;
          devselOe <= claimOk;
        end
        ST_DATA: if (strb.finalPhase) begin
          busState  <= ST_TURN;
          devselN   <= 1'b1;
          lastPhase <= 1'b1;
        end
        ST_TURN: begin
          busState  <= ST_IDLE;
          devselOe  <= 1'b0;
          lastPhase <= 1'b0;
        end
        default: busState <= ST_IDLE;
      endcase
    end
  end

  p_drive_needs_oe_r6: assert property (@(posedge clk) disable iff (!rstN)
    !devselN |-> devselOe);

  p_release_after_turn_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.turnEnd |=> (!devselOe && devselN));

  p_final_marks_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.finalPhase |=> lastPhase);

  p_last_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    lastPhase |=> !lastPhase);

endmodule

// File: rtl/pciTargetDecoder.sv
module pciTargetDecoder
  import pciTgtPkg::*;
#(
  parameter int DW  = 32,
  parameter int PCW = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameN,
  input  logic [DW-1:0]     ad,
  input  logic [DW/8-1:0]   cbeN,
  input  logic [DW-1:0]     memBase,
  input  logic [DW-1:0]     memMask,
  input  logic [DW-1:0]     ioBase,
  input  logic [DW-1:0]     ioMask,
  output logic [3:0]        cmdClass,
  output logic [DW-1:0]     addrOut,
  output logic [DW/8-1:0]   laneEn,
  output logic [PCW-1:0]    phaseCount,
  output logic              devselN,
  output logic              devselOe,
  output logic              lastPhase,
  output logic              eventPulse,
  output logic              badSpecial
);

  strobe_t   strb;
  logic      claimOk;
  cmdClass_e classQ;

  pciTgtControl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameN    (frameN),
    .claimOk   (claimOk),
    .strb      (strb),
    .devselN   (devselN),
    .devselOe  (devselOe),
    .lastPhase (lastPhase)
  );

  pciTgtDatapath #(.DW(DW), .PCW(PCW)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ad         (ad),
    .cbeN       (cbeN),
    .memBase    (memBase),
    .memMask    (memMask),
    .ioBase     (ioBase),
    .ioMask     (ioMask),
    .claimOk    (claimOk),
    .addrQ      (addrOut),
    .classQ     (classQ),
    .laneEn     (laneEn),
    .phaseCount (phaseCount),
    .eventPulse (eventPulse),
    .badSpecial (badSpecial)
  );

  assign cmdClass = classQ;

  p_reserved_no_claim_r4: assert property (@(posedge clk) disable iff (!rstN)
    (classQ == CLS_RSVD) |-> !devselOe);

  p_event_no_claim_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((classQ == CLS_IACK) || (classQ == CLS_SPEC) ||
     (classQ == CLS_CRD) || (classQ == CLS_CWR)) |-> !devselOe);

endmodule

// File: tb/pciTargetDecoder_bench.sv
module pciTargetDecoder_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameN = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbeN = 4'hF;
  logic [31:0] memBase = 32'h8000_0000;
  logic [31:0] memMask = 32'hFFFF_0000;
  logic [31:0] ioBase  = 32'h0000_1000;
  logic [31:0] ioMask  = 32'hFFFF_FF00;
  logic [3:0]  cmdClass;
  logic [31:0] addrOut;
  logic [3:0]  laneEn;
  logic [7:0]  phaseCount;
  logic        devselN, devselOe, lastPhase, eventPulse, badSpecial;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pciTargetDecoder u_pciTargetDecoder (
    .clk(clk), .rstN(rstN), .frameN(frameN), .ad(ad), .cbeN(cbeN),
    .memBase(memBase), .memMask(memMask), .ioBase(ioBase), .ioMask(ioMask),
    .cmdClass(cmdClass), .addrOut(addrOut), .laneEn(laneEn),
    .phaseCount(phaseCount), .devselN(devselN), .devselOe(devselOe),
    .lastPhase(lastPhase), .eventPulse(eventPulse), .badSpecial(badSpecial)
  );

  typedef struct packed {
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic [3:0]  n;
    logic [3:0]  cls;
    logic        claim;
    logic        evt;
    logic        bad;
  } txn_t;

  localparam int NT = 20;
  localparam txn_t TBL [NT] = '{
    '{4'b0110, 32'h8000_1234, 4'd2, 4'd5,  1'b1, 1'b0, 1'b0},
    '{4'b0111, 32'h8000_0010, 4'd1, 4'd6,  1'b1, 1'b0, 1'b0},
    '{4'b0110, 32'h9000_0000, 4'd2, 4'd5,  1'b0, 1'b0, 1'b0},
    '{4'b0010, 32'h0000_1044, 4'd1, 4'd3,  1'b1, 1'b0, 1'b0},
    '{4'b0011, 32'h0000_2000, 4'd2, 4'd4,  1'b0, 1'b0, 1'b0},
    '{4'b0011, 32'h0000_10FC, 4'd3, 4'd4,  1'b1, 1'b0, 1'b0},
    '{4'b0110, 32'h0000_1000, 4'd1, 4'd5,  1'b0, 1'b0, 1'b0},
    '{4'b1010, 32'h8000_0000, 4'd1, 4'd7,  1'b0, 1'b0, 1'b0},
    '{4'b1011, 32'h8000_0004, 4'd2, 4'd8,  1'b0, 1'b0, 1'b0},
    '{4'b1100, 32'h8000_FF00, 4'd3, 4'd9,  1'b1, 1'b0, 1'b0},
    '{4'b1110, 32'h8000_0100, 4'd1, 4'd10, 1'b1, 1'b0, 1'b0},
    '{4'b1111, 32'h8000_0200, 4'd2, 4'd11, 1'b1, 1'b0, 1'b0},
    '{4'b0000, 32'h8000_0000, 4'd1, 4'd1,  1'b0, 1'b1, 1'b0},
    '{4'b0001, 32'h0000_0000, 4'd1, 4'd2,  1'b0, 1'b1, 1'b0},
    '{4'b0001, 32'h0000_0004, 4'd1, 4'd2,  1'b0, 1'b1, 1'b1},
    '{4'b0100, 32'h8000_0000, 4'd1, 4'd0,  1'b0, 1'b0, 1'b0},
    '{4'b0101, 32'h8000_0000, 4'd1, 4'd0,  1'b0, 1'b0, 1'b0},
    '{4'b1000, 32'h8000_0000, 4'd1, 4'd0,  1'b0, 1'b0, 1'b0},
    '{4'b1001, 32'h0000_1000, 4'd1, 4'd0,  1'b0, 1'b0, 1'b0},
    '{4'b1101, 32'h8000_0000, 4'd2, 4'd0,  1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] beOf(input int i);
    return 4'(i * 3 + 1);
  endfunction

  // one transaction: address phase, n data phases, turnaround, return to idle
  task automatic runTxn(input logic [3:0] cmd, input logic [31:0] addr, input int n,
                        input logic [3:0] cls, input logic claim, input logic evt, input logic bad);
    @(negedge clk);
    frameN = 1'b0; ad = addr; cbeN = cmd;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == 0) begin
        chk(addrOut == addr, "R2 address latch", addrOut, addr);
        chk(cmdClass == cls, "R3/R4 command class", 32'(cmdClass), 32'(cls));
        chk(devselOe == claim, "R5/R13 claim enable", 32'(devselOe), 32'(claim));
        chk(devselN == !claim, "R6 devsel drive", 32'(devselN), 32'(!claim));
        chk(eventPulse == evt, "R11 event pulse", 32'(eventPulse), 32'(evt));
        chk(badSpecial == bad, "R12 malformed special", 32'(badSpecial), 32'(bad));
        chk(phaseCount == 0, "R10 count clear", 32'(phaseCount), 0);
      end else begin
        chk(laneEn == ~beOf(i-1), "R9 lane enables", 32'(laneEn), 32'(~beOf(i-1)));
        chk(phaseCount == 8'((i > 255) ? 255 : i), "R10 phase count", 32'(phaseCount), 32'((i > 255) ? 255 : i));
        chk(devselOe == claim && devselN == !claim, "R6/R13 devsel held", {devselOe, devselN}, {claim, !claim});
        if (i == 1) chk(eventPulse == 1'b0, "R11 pulse ends", 32'(eventPulse), 0);
        chk(lastPhase == 1'b0, "R8 not last yet", 32'(lastPhase), 0);
      end
      ad = 32'hA5A5_0000 + 32'(i); cbeN = beOf(i); frameN = (i == n - 1);
    end
    @(negedge clk);
    chk(lastPhase == 1'b1, "R8 last phase", 32'(lastPhase), 1);
    chk(laneEn == ~beOf(n-1), "R9 final lanes", 32'(laneEn), 32'(~beOf(n-1)));
    chk(phaseCount == 8'((n > 255) ? 255 : n), "R10 final count", 32'(phaseCount), 32'((n > 255) ? 255 : n));
    chk(devselN == 1'b1 && devselOe == claim, "R7 turnaround drive", {devselOe, devselN}, {claim, 1'b1});
    ad = '0; cbeN = 4'hF;
    @(negedge clk);
    chk(devselOe == 1'b0, "R7 release", 32'(devselOe), 0);
    chk(lastPhase == 1'b0, "R8 last one clock", 32'(lastPhase), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        done = 1;
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<100000", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(devselOe == 0 && devselN == 1, "R1 devsel reset", {devselOe, devselN}, 2'b01);
    chk(cmdClass == 0 && phaseCount == 0, "R1 class/count reset", {cmdClass, phaseCount}, 0);
    chk(lastPhase == 0 && eventPulse == 0 && badSpecial == 0, "R1 flags reset",
        {lastPhase, eventPulse, badSpecial}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(devselOe == 0, "R1 released before claim", 32'(devselOe), 0);

    for (int t = 0; t < NT; t++)
      runTxn(TBL[t].cmd, TBL[t].addr, int'(TBL[t].n), TBL[t].cls, TBL[t].claim, TBL[t].evt, TBL[t].bad);

    // R10 saturation over a long burst
    runTxn(4'b0111, 32'h8000_4000, 260, 4'd6, 1'b1, 1'b0, 1'b0);

    // R1 reset in the middle of a claimed transaction
    @(negedge clk);
    frameN = 1'b0; ad = 32'h8000_0040; cbeN = 4'b0110;
    @(negedge clk);
    cbeN = 4'h0; ad = 32'h1;
    @(negedge clk);
    chk(devselOe == 1'b1, "R6 claimed before reset", 32'(devselOe), 1);
    rstN = 1'b0;
    #1;
    chk(devselOe == 1'b0 && devselN == 1'b1, "R1 reset mid transaction", {devselOe, devselN}, 2'b01);
    frameN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    runTxn(4'b0010, 32'h0000_10AA, 1, 4'd3, 1'b1, 1'b0, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule